// File: doc/BRIEF.md
# Upset Event Classifier

This block sits behind a code-error detector that watches a converter's output and emits one record whenever two successive output codes differ by more than a threshold. Each record carries the sample-cycle stamp and the two codes involved. The classifier folds records that follow each other closely into a single physical upset event. An event stays open while new records keep arriving within a programmable idle window, measured in sample cycles. Once the window runs out, the event closes and the block emits one summary for it.

The summary holds the first and last record stamps, the record count, a class bit and the largest code step seen in the event. An event of exactly two records on neighbouring cycles is a short (digital) transient: the output jumps away and then comes back. Every other event is a long (analog) transient, and that includes a lone record. Two saturating counters tally closed events by class, and a host can read them and clear them synchronously.

Summaries leave on a valid/ready handshake. While a summary waits to be taken, the record input is held off. The window is normally set to 100 cycles, which is about 100 ns at 1 GS/s. That is far shorter than the millisecond spacing between particle strikes, so separate strikes are not merged.

Top module: `upset_event_classifier`

## Requirements
- R1: After reset no summary is valid, `rec_ready_o` is 1 and both class counters read 0.
- R2: An accepted record whose stamp is at most the last record's stamp plus `gap_win_i` joins the open event; the summary count equals the number of records merged.
- R3: An open event closes on the first clock edge at which `cur_cycle_i` is greater than its last stamp plus `gap_win_i` and the summary slot is free; `sum_valid_o` is 1 from the next cycle.
- R4: An event of exactly two records whose stamps differ by 1 is reported with `sum_long_o` = 0 (short).
- R5: Every other event, including a single record and two records further apart, is reported with `sum_long_o` = 1 (long).
- R6: `sum_start_o` and `sum_end_o` equal the stamps of the first and the last record of the event.
- R7: `sum_step_o` equals the largest absolute difference between `rec_code_i` and `rec_prev_i` over the event's records.
- R8: The record count saturates at 2^CNT_W-1 instead of wrapping.
- R9: On each close, the counter of the event's class increments by one and saturates at 2^CNT_W-1.
- R10: `cnt_clr_i` zeroes both counters on the next edge, and it wins over an increment at that edge.
- R11: While a summary is valid and not taken, `rec_ready_o` is 0 and every summary field holds its value.
- R12: A record stamped beyond the window closes the open event and starts a new event with itself at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_cycle_i | input | CYC_W | Current sample-cycle stamp |
| gap_win_i | input | WIN_W | Idle window in cycles (nominally 100) |
| cnt_clr_i | input | 1 | Synchronous clear of both class counters |
| rec_valid_i | input | 1 | Error record offered |
| rec_ready_o | output | 1 | Record accepted when high with valid |
| rec_cycle_i | input | CYC_W | Record cycle stamp |
| rec_code_i | input | CODE_W | Code that tripped the detector |
| rec_prev_i | input | CODE_W | Code it was compared against |
| sum_valid_o | output | 1 | Summary available |
| sum_ready_i | input | 1 | Summary taken when high with valid |
| sum_start_o | output | CYC_W | First record stamp |
| sum_end_o | output | CYC_W | Last record stamp |
| sum_count_o | output | CNT_W | Records in event, saturating |
| sum_long_o | output | 1 | 0 = short transient, 1 = long transient |
| sum_step_o | output | CODE_W | Largest code step in event |
| short_cnt_o | output | CNT_W | Short events closed |
| long_cnt_o | output | CNT_W | Long events closed |

## Verification
The hardest situation to reach is a close that coincides with something else. One case is an expired event while a summary is still unclaimed, where the close must wait and records stall. Another is a close landing on the very edge of a counter clear. The bench holds `sum_ready_i` low after a short event, keeps a record offered across the stall, and then releases the summary. The stale-stamped record then opens and immediately expires an event. For the clear case, the bench counts idle cycles from the last record so that the clear pulse lands on the closing edge. Window boundaries are probed with record gaps of exactly the window and one more.

// File: rtl/uec_pkg.sv
package uec_pkg;
    typedef enum logic {
        EV_SHORT = 1'b0,
        EV_LONG  = 1'b1
    } ev_class_e;

    localparam int NUM_CLASSES = 2;
endpackage

// File: rtl/uec_step_abs.sv
module uec_step_abs #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mag_o
);
    always_comb begin
        if (a_i >= b_i) mag_o = a_i - b_i;
        else            mag_o = b_i - a_i;
    end
endmodule

// File: rtl/uec_sat_ctr.sv
module uec_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                      cnt_d = '0;
        else if (inc_i && cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q_o = cnt_q;

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && !clr_i) |=> cnt_q == MAXV);
    // R10
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);
endmodule

// File: rtl/upset_event_classifier.sv
module upset_event_classifier #(
    parameter int CYC_W  = 32,
    parameter int WIN_W  = 16,
    parameter int CNT_W  = 16,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cur_cycle_i,
    input  logic [WIN_W-1:0]  gap_win_i,
    input  logic              cnt_clr_i,
    input  logic              rec_valid_i,
    output logic              rec_ready_o,
    input  logic [CYC_W-1:0]  rec_cycle_i,
    input  logic [CODE_W-1:0] rec_code_i,
    input  logic [CODE_W-1:0] rec_prev_i,
    output logic              sum_valid_o,
    input  logic              sum_ready_i,
    output logic [CYC_W-1:0]  sum_start_o,
    output logic [CYC_W-1:0]  sum_end_o,
    output logic [CNT_W-1:0]  sum_count_o,
    output logic              sum_long_o,
    output logic [CODE_W-1:0] sum_step_o,
    output logic [CNT_W-1:0]  short_cnt_o,
    output logic [CNT_W-1:0]  long_cnt_o
);
    import uec_pkg::*;

    localparam int             EXT_W = CYC_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              open;
        logic [CYC_W-1:0]  first;
        logic [CYC_W-1:0]  last;
        logic [CNT_W-1:0]  n;
        logic [CODE_W-1:0] mx;
        logic              sv;
        logic [CYC_W-1:0]  s_start;
        logic [CYC_W-1:0]  s_end;
        logic [CNT_W-1:0]  s_n;
        ev_class_e         s_cls;
        logic [CODE_W-1:0] s_mx;
    } st_t;

    st_t st_d, st_q;

    logic [CODE_W-1:0]      step;
    logic [EXT_W-1:0]       limit;
    logic                   accept, slot_free, expired, far_rec, closing, is_short;
    logic [NUM_CLASSES-1:0] inc;
    logic [CNT_W-1:0]       cls_cnt [NUM_CLASSES];

    uec_step_abs #(.W(CODE_W)) u_step (
        .a_i   (rec_code_i),
        .b_i   (rec_prev_i),
        .mag_o (step)
    );

    always_comb begin
        st_d      = st_q;
        accept    = rec_valid_i && !st_q.sv;
        slot_free = !st_q.sv || sum_ready_i;
        limit     = {1'b0, st_q.last} + EXT_W'(gap_win_i);
        expired   = st_q.open && ({1'b0, cur_cycle_i} > limit);
        far_rec   = accept && st_q.open && ({1'b0, rec_cycle_i} > limit);
        closing   = st_q.open && slot_free && (expired || far_rec);
        is_short  = (st_q.n == CNT_W'(2)) && ((st_q.last - st_q.first) == CYC_W'(1));
        inc       = '0;

        if (st_q.sv && sum_ready_i) st_d.sv = 1'b0;

        if (closing) begin
            st_d.sv      = 1'b1;
            st_d.s_start = st_q.first;
            st_d.s_end   = st_q.last;
            st_d.s_n     = st_q.n;
            st_d.s_cls   = is_short ? EV_SHORT : EV_LONG;
            st_d.s_mx    = st_q.mx;
            inc[EV_SHORT] = is_short;
            inc[EV_LONG]  = !is_short;
        end

        if (accept) begin
            if (!st_q.open || closing) begin
                st_d.open  = 1'b1;
                st_d.first = rec_cycle_i;
                st_d.last  = rec_cycle_i;
                st_d.n     = CNT_W'(1);
                st_d.mx    = step;
            end else begin
                st_d.last = rec_cycle_i;
                if (st_q.n != CNT_MAX) st_d.n = st_q.n + 1'b1;
                if (step > st_q.mx)    st_d.mx = step;
            end
        end else if (closing) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls_ctr
        uec_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (cnt_clr_i),
            .inc_i (inc[g]),
            .q_o   (cls_cnt[g])
        );
    end

    assign rec_ready_o = !st_q.sv;
    assign sum_valid_o = st_q.sv;
    assign sum_start_o = st_q.s_start;
    assign sum_end_o   = st_q.s_end;
    assign sum_count_o = st_q.s_n;
    assign sum_long_o  = st_q.s_cls == EV_LONG;
    assign sum_step_o  = st_q.s_mx;
    assign short_cnt_o = cls_cnt[EV_SHORT];
    assign long_cnt_o  = cls_cnt[EV_LONG];

    // R11
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid_o && !sum_ready_i) |=> (sum_valid_o && !rec_ready_o
            && $stable(sum_start_o) && $stable(sum_end_o) && $stable(sum_count_o)
            && $stable(sum_long_o) && $stable(sum_step_o)));
    // R4
    short_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid_o && !sum_long_o) |-> (sum_count_o == CNT_W'(2)
            && sum_end_o == sum_start_o + CYC_W'(1)));
    // R6
    span_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid_o |-> sum_end_o >= sum_start_o);
    // R2
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid_o |-> sum_count_o != '0);
    // R3
    close_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && !st_q.sv && ({1'b0, cur_cycle_i} > {1'b0, st_q.last} + EXT_W'(gap_win_i)))
            |=> sum_valid_o);
endmodule

// File: tb/upset_event_classifier_test.sv
`timescale 1ns/1ps
module upset_event_classifier_test;
    localparam int CYC_W = 32, WIN_W = 16, CNT_W = 4, CODE_W = 8;
    localparam longint CMAX = (64'd1 << CNT_W) - 1;
    localparam int WIN = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [CYC_W-1:0] cur_cycle = '0;
    logic [WIN_W-1:0] gap_win = WIN_W'(WIN);
    logic cnt_clr = 1'b0, rec_valid = 1'b0, rec_ready, sum_valid, sum_ready = 1'b1, sum_long;
    logic [CYC_W-1:0] rec_cycle = '0, sum_start, sum_end;
    logic [CODE_W-1:0] rec_code = '0, rec_prev = '0, sum_step;
    logic [CNT_W-1:0] sum_count, short_cnt, long_cnt;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    upset_event_classifier #(.CYC_W(CYC_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) uut (
        .clk(clk), .rst_n(rst_n), .cur_cycle_i(cur_cycle), .gap_win_i(gap_win),
        .cnt_clr_i(cnt_clr), .rec_valid_i(rec_valid), .rec_ready_o(rec_ready),
        .rec_cycle_i(rec_cycle), .rec_code_i(rec_code), .rec_prev_i(rec_prev),
        .sum_valid_o(sum_valid), .sum_ready_i(sum_ready), .sum_start_o(sum_start),
        .sum_end_o(sum_end), .sum_count_o(sum_count), .sum_long_o(sum_long),
        .sum_step_o(sum_step), .short_cnt_o(short_cnt), .long_cnt_o(long_cnt)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cur_cycle <= '0;
        else        cur_cycle <= cur_cycle + 1;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: an event list built from accepted records.
    bit     m_open, m_sv;
    longint m_first, m_last, m_n, m_mx, m_sn, m_smx, m_ss, m_se, m_cs, m_cl;
    bit     m_slong;
    longint q_stamp[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_sv = 0; m_cs = 0; m_cl = 0; m_n = 0;
            q_stamp.delete();
        end else begin
            bit acc, closing, shortev;
            longint lim, stp;
            acc = rec_valid && !m_sv;
            lim = m_last + longint'(gap_win);
            stp = (rec_code > rec_prev) ? rec_code - rec_prev : rec_prev - rec_code;
            closing = m_open && (!m_sv || sum_ready) &&
                      (longint'(cur_cycle) > lim || (acc && longint'(rec_cycle) > lim));
            if (m_sv && sum_ready) m_sv = 0;
            if (closing) begin
                shortev = (q_stamp.size() == 2) && (q_stamp[1] - q_stamp[0] == 1);
                m_sv = 1; m_ss = q_stamp[0]; m_se = q_stamp[$];
                m_sn = (q_stamp.size() > CMAX) ? CMAX : q_stamp.size();
                m_slong = !shortev; m_smx = m_mx;
                if (shortev) m_cs = (m_cs < CMAX) ? m_cs + 1 : m_cs;
                else         m_cl = (m_cl < CMAX) ? m_cl + 1 : m_cl;
                q_stamp.delete();
                m_open = 0;
            end
            if (cnt_clr) begin m_cs = 0; m_cl = 0; end
            if (acc) begin
                if (!m_open) m_mx = 0;
                m_open = 1;
                q_stamp.push_back(longint'(rec_cycle));
                m_last = longint'(rec_cycle);
                if (stp > m_mx) m_mx = stp;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 sum_valid", sum_valid, m_sv);
            chk("R11 rec_ready", rec_ready, !m_sv);
            chk("R9 short_cnt", short_cnt, m_cs);
            chk("R9 long_cnt", long_cnt, m_cl);
            if (m_sv && sum_valid) begin
                chk("R6 start", sum_start, m_ss);
                chk("R6 end", sum_end, m_se);
                chk("R2 count", sum_count, m_sn);
                chk("R4/R5 class", sum_long, m_slong);
                chk("R7 step", sum_step, m_smx);
            end
        end
    end

    int     t_num = 0;
    longint t_n = 0, t_step = 0;
    bit     t_long = 0;
    always @(posedge clk) begin
        if (rst_n && sum_valid && sum_ready) begin
            t_num++; t_n = sum_count; t_long = sum_long; t_step = sum_step;
        end
    end

    task automatic put(input int now_c, input int prev_c);
        bit r;
        rec_valid = 1; rec_cycle = cur_cycle;
        rec_code = CODE_W'(now_c); rec_prev = CODE_W'(prev_c);
        do begin
            r = rec_ready;
            @(negedge clk);
        end while (!r);
        rec_valid = 0;
    endtask

    task automatic idle(input int k);
        rec_valid = 0;
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 sum_valid", sum_valid, 0);
        chk("R1 rec_ready", rec_ready, 1);
        chk("R1 counters", short_cnt + long_cnt, 0);

        put(90, 40); put(40, 90); idle(WIN + 4);               // short
        chk("R4 short class", t_long, 0);
        chk("R7 step", t_step, 50);
        put(7, 3); idle(WIN + 4);                              // single
        chk("R5 single long", t_long, 1);
        put(1, 20); idle(1); put(20, 1); idle(WIN + 4);        // two, 2 apart
        chk("R5 gap2 long", t_long, 1);

        put(10, 30); put(5, 6); idle(3); put(200, 60); idle(2);
        put(0, 9); put(9, 0); idle(WIN + 4);                   // merged long run
        chk("R2 merged count", t_n, 5);
        chk("R7 max step", t_step, 140);

        for (int i = 0; i < 20; i++) put(i, i + 7);
        idle(WIN + 4);
        chk("R8 count saturates", t_n, CMAX);

        base = t_num;
        put(3, 4); idle(WIN - 1); put(4, 3); idle(WIN + 4);    // gap == window: merge
        chk("R2 boundary merge", t_num - base, 1);
        chk("R2 boundary count", t_n, 2);
        base = t_num;
        put(3, 4); idle(WIN); put(4, 3); idle(WIN + 4);        // gap == window+1: split
        chk("R12 split events", t_num - base, 2);
        chk("R12 new event count", t_n, 1);

        sum_ready = 0;                                         // back-pressure
        put(50, 0); put(0, 50); idle(WIN + 4);
        rec_valid = 1; rec_cycle = cur_cycle; rec_code = 8'd66; rec_prev = 8'd6;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R11 stalled ready", rec_ready, 0);
        end
        sum_ready = 1;
        repeat (2) @(negedge clk);
        rec_valid = 0;
        idle(WIN + 4);
        chk("R7 stalled record step", t_step, 60);

        for (int i = 0; i < 17; i++) begin put(2, 9); idle(WIN + 4); end
        chk("R9 long saturates", long_cnt, CMAX);

        put(8, 1); idle(WIN);                                  // clear on closing edge
        cnt_clr = 1; @(negedge clk); cnt_clr = 0;
        chk("R10 short cleared", short_cnt, 0);
        chk("R10 long cleared", long_cnt, 0);
        idle(WIN + 4);
        put(1, 2); put(2, 1); idle(WIN + 4);
        chk("R9 short after clear", short_cnt, 1);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule